// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block holds the inter-processor interrupt state of one core. It has a 32-bit register interface with two write sources. The local core can read and write through its own port. A send dispatcher writes on behalf of remote cores through a second, write-only port. The bank contains:

- a read-only pending status word,
- an enable mask,
- two write-only ports that set or clear pending bits,
- an eight-word mailbox that software on other cores uses to pass arguments.

The interrupt output is not a continuous function of status and enable. It is raised only when a set write leaves an enabled bit pending. It is lowered only when a clear write empties the status word while the enable mask is nonzero. Between those events the line holds its value.

Register offsets, taken from the low eight address bits:

| Offset | Register |
|---|---|
| 0x00 | status |
| 0x04 | enable |
| 0x08 | set |
| 0x0C | clear |
| 0x20 + 4*i | mailbox word i, i = 0..7 |

Read data, the unimplemented-access flag and the read-only-write flag are combinational with the request. The interrupt line is registered and changes at the clock edge that applies the write.

Top module: `ipi_core_bank`

## Requirements
- R1: Only address bits [7:0] are decoded; an address whose upper bits differ from a register's offset reaches that same register, for both reads and writes.
- R2: A write to status (0x00) leaves status unchanged and raises `roWriteErr` in that cycle.
- R3: A write to set (0x08) ORs its data into status. The line is raised at the next edge if the resulting status has a bit that is also set in the enable value held before the edge. A set write with no such bit leaves the line unchanged.
- R4: A write to clear (0x0C) removes the written bits from status. The line is lowered only if status becomes zero and the enable value held before the edge is nonzero. Otherwise the line is unchanged, which includes the case where the enable mask is zero.
- R5: Reads of set and clear return zero.
- R6: Mailbox word i sits at offset 0x20 + 4*i (i = 0..7). A write stores the full 32-bit word, and a read returns it.
- R7: A write to enable (0x04) replaces the mask and does not by itself change the interrupt line.
- R8: An access to any other offset, including one with address bits [1:0] nonzero, reads zero, changes no state and raises `unimplPulse` in that cycle.
- R9: A synchronous active-high reset clears status, enable, every mailbox word and the interrupt line.
- R10: When set and clear writes take effect in the same cycle, the set is applied first (including its raise test) and then the clear (including its lower test).
- R11: When both ports write the enable register, or the same mailbox word, in one cycle, the remote port's data is kept. Set bits from both ports are merged, and so are clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lclWrEn | input | 1 | Local write strobe |
| lclRdEn | input | 1 | Local read strobe |
| lclAddr | input | ADDR_W | Local access address |
| lclWrData | input | 32 | Local write data |
| lclRdData | output | 32 | Local read data, combinational |
| rmtWrEn | input | 1 | Dispatcher write strobe |
| rmtAddr | input | ADDR_W | Dispatcher write address |
| rmtWrData | input | 32 | Dispatcher write data |
| irqOut | output | 1 | Interrupt line to the core |
| unimplPulse | output | 1 | Access to an undecoded offset this cycle |
| roWriteErr | output | 1 | Write to the read-only status register this cycle |

## Verification
The bench targets the asymmetric lower rule by emptying status while the enable mask is zero. A design that used a continuous OR of status and enable would drop the line there, and the bench expects it to stay high. It writes enable alone while bits are pending. A design that re-evaluated the line on an enable write would raise or drop it too early. It drives set and clear of the same bit in one cycle, and of different bits. A design that applied the clear first would leave a stray pending bit or a raised line. It also checks aliased high address bits, misaligned and undecoded offsets, and colliding writes from both ports. In every cycle, directed and random, the outputs are compared against a behavioural model.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;
  localparam int DATA_W    = 32;
  localparam int MBX_N     = 8;
  localparam int MBX_IDX_W = $clog2(MBX_N);
  localparam int DEC_W     = 8;

  localparam logic [DEC_W-1:0] OFS_STAT = 8'h00;
  localparam logic [DEC_W-1:0] OFS_EN   = 8'h04;
  localparam logic [DEC_W-1:0] OFS_SET  = 8'h08;
  localparam logic [DEC_W-1:0] OFS_CLR  = 8'h0C;
  localparam logic [DEC_W-1:0] OFS_MBX  = 8'h20;

  typedef enum logic [2:0] {K_STAT, K_EN, K_SET, K_CLR, K_MBX, K_NONE} regKind_e;
  typedef enum logic [1:0] {RD_ZERO, RD_STAT, RD_EN, RD_MBX} rdSel_e;

  typedef struct packed {
    logic                 setL;
    logic                 setR;
    logic                 clrL;
    logic                 clrR;
    logic                 enL;
    logic                 enR;
    logic                 mbxL;
    logic                 mbxR;
    logic [MBX_IDX_W-1:0] idxL;
    logic [MBX_IDX_W-1:0] idxR;
    rdSel_e               rdSel;
  } bankStrobe_t;
endpackage

// File: rtl/ipi_bank_ctrl.sv
module ipi_bank_ctrl
  import ipi_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lclWrEn,
  input  logic             lclRdEn,
  input  logic [DEC_W-1:0] lclOfs,
  input  logic             rmtWrEn,
  input  logic [DEC_W-1:0] rmtOfs,
  output bankStrobe_t      strb,
  output logic             unimpl,
  output logic             roErr
);
  localparam logic [DEC_W:0] MBX_END = {1'b0, OFS_MBX} + (DEC_W+1)'(4 * MBX_N);

  function automatic regKind_e kindOf(input logic [DEC_W-1:0] ofs);
    regKind_e k;
    if (ofs[1:0] != 2'b00)                                 k = K_NONE;
    else if (ofs == OFS_STAT)                              k = K_STAT;
    else if (ofs == OFS_EN)                                k = K_EN;
    else if (ofs == OFS_SET)                               k = K_SET;
    else if (ofs == OFS_CLR)                               k = K_CLR;
    else if (ofs >= OFS_MBX && {1'b0, ofs} < MBX_END)      k = K_MBX;
    else                                                   k = K_NONE;
    return k;
  endfunction

  function automatic logic [MBX_IDX_W-1:0] idxOf(input logic [DEC_W-1:0] ofs);
    logic [DEC_W-1:0] rel;
    rel = ofs - OFS_MBX;
    return rel[2 +: MBX_IDX_W];
  endfunction

  regKind_e kindL, kindR;

  always_comb begin
    kindL = kindOf(lclOfs);
    kindR = kindOf(rmtOfs);

    strb.setL = lclWrEn && (kindL == K_SET);
    strb.clrL = lclWrEn && (kindL == K_CLR);
    strb.enL  = lclWrEn && (kindL == K_EN);
    strb.mbxL = lclWrEn && (kindL == K_MBX);
    strb.idxL = idxOf(lclOfs);

    strb.setR = rmtWrEn && (kindR == K_SET);
    strb.clrR = rmtWrEn && (kindR == K_CLR);
    strb.enR  = rmtWrEn && (kindR == K_EN);
    strb.mbxR = rmtWrEn && (kindR == K_MBX);
    strb.idxR = idxOf(rmtOfs);

    strb.rdSel = RD_ZERO;
    if (lclRdEn) begin
      case (kindL)
        K_STAT:  strb.rdSel = RD_STAT;
        K_EN:    strb.rdSel = RD_EN;
        K_MBX:   strb.rdSel = RD_MBX;
        default: strb.rdSel = RD_ZERO;
      endcase
    end

    roErr  = (lclWrEn && kindL == K_STAT) || (rmtWrEn && kindR == K_STAT);
    unimpl = ((lclWrEn || lclRdEn) && kindL == K_NONE) || (rmtWrEn && kindR == K_NONE);
  end

  // R8
  lcl_one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.setL, strb.clrL, strb.enL, strb.mbxL, unimpl && lclWrEn && !rmtWrEn}));
endmodule

// File: rtl/ipi_bank_dp.sv
module ipi_bank_dp
  import ipi_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bankStrobe_t       strb,
  input  logic [MBX_IDX_W-1:0] rdIdx,
  input  logic [DATA_W-1:0] lclData,
  input  logic [DATA_W-1:0] rmtData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [DATA_W-1:0] statQ, enQ, statNext, enNext, setBits, clrBits, afterSet;
  logic [DATA_W-1:0] mbxQ [MBX_N];
  logic              irqQ, irqNext, irqAfterSet, setAny, clrAny;

  always_comb begin
    setAny   = strb.setL || strb.setR;
    clrAny   = strb.clrL || strb.clrR;
    setBits  = (strb.setL ? lclData : '0) | (strb.setR ? rmtData : '0);
    clrBits  = (strb.clrL ? lclData : '0) | (strb.clrR ? rmtData : '0);
    afterSet = statQ | setBits;
    statNext = afterSet & ~clrBits;

    irqAfterSet = irqQ;
    if (setAny && (afterSet != '0) && ((afterSet & enQ) != '0)) irqAfterSet = 1'b1;
    irqNext = irqAfterSet;
    if (clrAny && (statNext == '0) && (enQ != '0)) irqNext = 1'b0;

    if (strb.enR)      enNext = rmtData;
    else if (strb.enL) enNext = lclData;
    else               enNext = enQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statQ <= '0;
      enQ   <= '0;
      irqQ  <= 1'b0;
    end else begin
      statQ <= statNext;
      enQ   <= enNext;
      irqQ  <= irqNext;
    end
  end

  for (genvar g = 0; g < MBX_N; g++) begin : g_mbx
    always_ff @(posedge clk) begin
      if (rst)
        mbxQ[g] <= '0;
      else if (strb.mbxR && strb.idxR == MBX_IDX_W'(g))
        mbxQ[g] <= rmtData;
      else if (strb.mbxL && strb.idxL == MBX_IDX_W'(g))
        mbxQ[g] <= lclData;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_STAT: rdData = statQ;
      RD_EN:   rdData = enQ;
      RD_MBX:  rdData = mbxQ[rdIdx];
      default: rdData = '0;
    endcase
  end

  assign irq = irqQ;

  // R3
  raise_only_on_set_chk: assert property (@(posedge clk) disable iff (rst)
    !setAny |=> !$rose(irqQ));

  // R3
  raise_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irqQ) |-> (statQ != '0));

  // R4
  lower_only_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clrAny |=> !$fell(irqQ));

  // R4
  lower_leaves_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irqQ) |-> (statQ == '0));

  // R2
  no_bit_without_set_chk: assert property (@(posedge clk) disable iff (rst)
    !setAny |=> ((statQ & ~$past(statQ)) == '0));

  // R7
  line_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!setAny && !clrAny) |=> $stable(irqQ));
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
  import ipi_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lclWrEn,
  input  logic              lclRdEn,
  input  logic [ADDR_W-1:0] lclAddr,
  input  logic [DATA_W-1:0] lclWrData,
  output logic [DATA_W-1:0] lclRdData,
  input  logic              rmtWrEn,
  input  logic [ADDR_W-1:0] rmtAddr,
  input  logic [DATA_W-1:0] rmtWrData,
  output logic              irqOut,
  output logic              unimplPulse,
  output logic              roWriteErr
);
  localparam int HI_W = ADDR_W - DEC_W;

  bankStrobe_t strb;
  logic [DEC_W-1:0] lclOfs, rmtOfs, rdRel;
  logic unusedAddrHi;

  assign lclOfs       = lclAddr[DEC_W-1:0];
  assign rmtOfs       = rmtAddr[DEC_W-1:0];
  assign unusedAddrHi = ^{lclAddr[ADDR_W-1 -: HI_W], rmtAddr[ADDR_W-1 -: HI_W]};
  assign rdRel        = lclOfs - OFS_MBX;

  ipi_bank_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .lclWrEn (lclWrEn),
    .lclRdEn (lclRdEn),
    .lclOfs  (lclOfs),
    .rmtWrEn (rmtWrEn),
    .rmtOfs  (rmtOfs),
    .strb    (strb),
    .unimpl  (unimplPulse),
    .roErr   (roWriteErr)
  );

  ipi_bank_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .rdIdx   (rdRel[2 +: MBX_IDX_W]),
    .lclData (lclWrData),
    .rmtData (rmtWrData),
    .rdData  (lclRdData),
    .irq     (irqOut)
  );
endmodule

// File: tb/test_ipi_core_bank.sv
module test_ipi_core_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lclWrEn = 0, lclRdEn = 0, rmtWrEn = 0;
  logic [11:0] lclAddr = 0, rmtAddr = 0;
  logic [31:0] lclWrData = 0, rmtWrData = 0;
  logic [31:0] lclRdData;
  logic        irqOut, unimplPulse, roWriteErr;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mStat = 0, mEn = 0;
  logic [31:0] mMbx [8];
  logic        mIrq = 0;

  always #5 clk = ~clk;

  ipi_core_bank #(.ADDR_W(12)) i_ipi_core_bank (
    .clk(clk), .rst(rst),
    .lclWrEn(lclWrEn), .lclRdEn(lclRdEn), .lclAddr(lclAddr),
    .lclWrData(lclWrData), .lclRdData(lclRdData),
    .rmtWrEn(rmtWrEn), .rmtAddr(rmtAddr), .rmtWrData(rmtWrData),
    .irqOut(irqOut), .unimplPulse(unimplPulse), .roWriteErr(roWriteErr)
  );

  // 0 status, 1 enable, 2 set, 3 clear, 4 mailbox, 5 undecoded
  function automatic int kindB(input logic [11:0] a);
    int o;
    o = int'(a[7:0]);
    if (o % 4 != 0) return 5;
    if (o == 0)  return 0;
    if (o == 4)  return 1;
    if (o == 8)  return 2;
    if (o == 12) return 3;
    if (o >= 32 && o < 64) return 4;
    return 5;
  endfunction

  function automatic int idxB(input logic [11:0] a);
    return (int'(a[7:0]) - 32) / 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelTick();
    logic [31:0] sb, cb, mid;
    int kl, kr;
    if (rst) begin
      mStat = 0; mEn = 0; mIrq = 0;
      for (int i = 0; i < 8; i++) mMbx[i] = 0;
      return;
    end
    kl = lclWrEn ? kindB(lclAddr) : -1;
    kr = rmtWrEn ? kindB(rmtAddr) : -1;
    sb = 0; cb = 0;
    if (kl == 2) sb |= lclWrData;
    if (kr == 2) sb |= rmtWrData;
    if (kl == 3) cb |= lclWrData;
    if (kr == 3) cb |= rmtWrData;
    mid = mStat | sb;
    if ((kl == 2 || kr == 2) && (mid & mEn) != 0) mIrq = 1;
    mStat = mid & ~cb;
    if ((kl == 3 || kr == 3) && mStat == 0 && mEn != 0) mIrq = 0;
    if (kl == 4) mMbx[idxB(lclAddr)] = lclWrData;
    if (kr == 4) mMbx[idxB(rmtAddr)] = rmtWrData;
    if (kl == 1) mEn = lclWrData;
    if (kr == 1) mEn = rmtWrData;
  endtask

  task automatic compareNow(input string tag);
    logic [31:0] er;
    logic eu, eo;
    int kl, kr;
    kl = kindB(lclAddr);
    kr = kindB(rmtAddr);
    er = 0;
    if (lclRdEn) begin
      if (kl == 0) er = mStat;
      else if (kl == 1) er = mEn;
      else if (kl == 4) er = mMbx[idxB(lclAddr)];
    end
    eu = ((lclWrEn || lclRdEn) && kl == 5) || (rmtWrEn && kr == 5);
    eo = (lclWrEn && kl == 0) || (rmtWrEn && kr == 0);
    chk({tag, " rdData"}, lclRdData, er);
    chk({tag, " unimpl"}, {31'b0, unimplPulse}, {31'b0, eu});
    chk({tag, " roErr"}, {31'b0, roWriteErr}, {31'b0, eo});
    chk({tag, " irq"}, {31'b0, irqOut}, {31'b0, mIrq});
  endtask

  task automatic step(input logic lw, input logic lr, input logic [11:0] la,
                      input logic [31:0] ld, input logic rw, input logic [11:0] ra,
                      input logic [31:0] rd, input string tag);
    @(negedge clk);
    lclWrEn = lw; lclRdEn = lr; lclAddr = la; lclWrData = ld;
    rmtWrEn = rw; rmtAddr = ra; rmtWrData = rd;
    #2;
    compareNow(tag);
    @(posedge clk);
    #1;
    modelTick();
  endtask

  task automatic lw(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, 0, 0, 0, tag);
  endtask
  task automatic lr(input logic [11:0] a, input string tag);
    step(0, 1, a, 0, 0, 0, 0, tag);
  endtask
  task automatic rwr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 1, a, d, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 8; i++) mMbx[i] = 0;
    rst = 1;
    repeat (3) idle("R9 reset");
    rst = 0;
    lr(12'h000, "R9 status after reset");
    lr(12'h004, "R9 enable after reset");
    lr(12'h03C, "R9 mailbox after reset");

    lw(12'h004, 32'h1, "R7 enable write");
    lw(12'h008, 32'h4, "R3 set without enabled bit");
    chk("R3 no raise", {31'b0, irqOut}, 32'h0);
    lw(12'h008, 32'h1, "R3 set enabled bit");
    idle("R3 raise");
    chk("R3 raised", {31'b0, irqOut}, 32'h1);
    lr(12'h000, "R3 status merged");
    chk("R3 status value", lclRdData, 32'h5);
    lr(12'h008, "R5 set reads zero");
    lr(12'h00C, "R5 clear reads zero");
    lw(12'h00C, 32'h1, "R4 partial clear");
    idle("R4 partial clear keeps line");
    chk("R4 line held", {31'b0, irqOut}, 32'h1);
    lw(12'h00C, 32'h4, "R4 clear to empty");
    idle("R4 lowered");
    chk("R4 lowered", {31'b0, irqOut}, 32'h0);

    // asymmetric lower: enable zero keeps line up
    lw(12'h008, 32'h1, "R4 re-raise");
    lw(12'h004, 32'h0, "R7 enable cleared while raised");
    idle("R7 line unchanged");
    chk("R7 line stays", {31'b0, irqOut}, 32'h1);
    lw(12'h00C, 32'h1, "R4 clear with enable zero");
    idle("R4 line kept");
    chk("R4 asymmetric", {31'b0, irqOut}, 32'h1);
    lw(12'h004, 32'h2, "R7 enable set alone");
    lw(12'h00C, 32'h0, "R4 empty clear with enable");
    idle("R4 lowered by empty clear");
    chk("R4 late lower", {31'b0, irqOut}, 32'h0);
    lw(12'h008, 32'h8, "R7 pend disabled bit");
    lw(12'h004, 32'h8, "R7 enable matching pending");
    idle("R7 no raise from enable");
    chk("R7 no raise", {31'b0, irqOut}, 32'h0);
    lw(12'h00C, 32'h8, "R4 cleanup");

    lw(12'h000, 32'hFF, "R2 status write");
    lr(12'h000, "R2 status unchanged");
    rwr(12'h000, 32'h3, "R2 remote status write");
    lr(12'h000, "R2 status still unchanged");

    for (int i = 0; i < 8; i++) lw(12'h020 + 12'(4 * i), 32'hA500_0000 + 32'(i * 17), "R6 mailbox write");
    for (int i = 0; i < 8; i++) lr(12'h020 + 12'(4 * i), "R6 mailbox read");
    rwr(12'h02C, 32'hDEAD_BEEF, "R6 remote mailbox write");
    lr(12'h02C, "R6 remote word");
    chk("R6 word 3", lclRdData, 32'hDEAD_BEEF);

    lw(12'h304, 32'h0000_0030, "R1 aliased enable write");
    lr(12'h004, "R1 enable via base");
    chk("R1 alias", lclRdData, 32'h30);
    lr(12'hA24, "R1 aliased mailbox read");
    chk("R1 alias mbx", lclRdData, 32'hA500_0011);

    lr(12'h010, "R8 undecoded read");
    lw(12'h040, 32'hFFFF_FFFF, "R8 undecoded write");
    lw(12'h005, 32'hFFFF_FFFF, "R8 misaligned write");
    rwr(12'h01C, 32'h1, "R8 remote undecoded");
    lr(12'h004, "R8 enable untouched");
    lr(12'h000, "R8 status untouched");
    lr(12'h03C, "R8 mailbox untouched");

    // same-cycle set and clear
    lw(12'h004, 32'h8, "R10 enable");
    step(1, 0, 12'h008, 32'h8, 1, 12'h00C, 32'h8, "R10 set and clear same bit");
    idle("R10 after same bit");
    chk("R10 no residue irq", {31'b0, irqOut}, 32'h0);
    lr(12'h000, "R10 status empty");
    chk("R10 status", lclRdData, 32'h0);
    step(1, 0, 12'h00C, 32'h10, 1, 12'h008, 32'h18, "R10 remote set local clear");
    idle("R10 raise kept");
    chk("R10 line up", {31'b0, irqOut}, 32'h1);
    lr(12'h000, "R10 status residue");
    chk("R10 status", lclRdData, 32'h8);
    lw(12'h00C, 32'h8, "R10 cleanup");

    step(1, 0, 12'h004, 32'h11, 1, 12'h004, 32'h22, "R11 enable collision");
    lr(12'h004, "R11 remote enable kept");
    chk("R11 enable", lclRdData, 32'h22);
    step(1, 0, 12'h034, 32'h1111, 1, 12'h034, 32'h2222, "R11 mailbox collision");
    lr(12'h034, "R11 remote word kept");
    chk("R11 mailbox", lclRdData, 32'h2222);
    step(1, 0, 12'h008, 32'h1, 1, 12'h008, 32'h2, "R11 set merge");
    lr(12'h000, "R11 merged status");
    chk("R11 merged", lclRdData, 32'h3);
    step(1, 0, 12'h00C, 32'h1, 1, 12'h00C, 32'h2, "R11 clear merge");
    lr(12'h000, "R11 cleared status");
    chk("R11 cleared", lclRdData, 32'h0);

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a, b;
      logic [7:0] pick [14];
      pick = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h38,
               8'h3C, 8'h10, 8'h40, 8'h05, 8'hFC};
      a = {4'($urandom), pick[$urandom % 14]};
      b = {4'($urandom), pick[$urandom % 14]};
      step(1'($urandom), 1'($urandom), a, $urandom & 32'h0000_000F,
           1'($urandom), b, $urandom & 32'h0000_000F, "R3 R4 R10 R11 random");
    end

    rst = 1;
    idle("R9 mid-run reset");
    rst = 0;
    lr(12'h000, "R9 status cleared");
    lr(12'h004, "R9 enable cleared");
    lr(12'h024, "R9 mailbox cleared");
    chk("R9 irq cleared", {31'b0, irqOut}, 32'h0);

    finishRun();
  end
endmodule